// File: doc/BRIEF.md
# Transceiver MDIO Bring-up Sequencer

After reset, this block configures one serial transceiver macro through a management (MDIO) frame engine. A one-cycle start pulse launches a fixed programme of register writes. Each write becomes two Clause 45 frames: first an address frame that carries the register number, then a write frame that carries the value. The programme first sets the transmit configuration of each lane, then the receive configuration of each lane, and finally switches the PLL on.

Frames leave the block one at a time on a 32-bit valid/ready port. Once a frame is accepted, the sequencer waits for the engine's completion pulse before it offers the next one. A one-bit port select picks which of two transceiver instances the frames address. The select is captured when the start pulse is taken. When the last write frame has completed, a done flag rises and stays high until the next start.

Top module: `serdes_init_seq`

## Requirements
- R1: After reset, frameValid, busy and done are all 0.
- R2: An address frame is {2'b00, opcode 2'b00, 5-bit port address, device address 5'h1E, turnaround 2'b10, 16-bit register address}. Its upper half is 0x007A for port 0 and 0x00FA for port 1.
- R3: A write frame uses opcode 2'b01 and carries the data in bits 15:0. Its upper half is 0x107A for port 0 and 0x10FA for port 1. It always follows the address frame of the same register.
- R4: The writes go in this order. First come TX lanes 0..3, at 0x8100+4c (low) and then 0x8100+4c+1 (high). Next come RX lanes 0..3, at 0x8120+4c (low) and then +1 (high). Last comes 0x8000.
- R5: TX low takes 0x9F01 and TX high takes 0x0000. RX low takes 0x9101 and RX high takes 0x0008. The PLL register takes 0x000B.
- R6: While frameValid is high and frameReady is low, frameValid stays high and frameData is unchanged.
- R7: After a frame is accepted (frameValid and frameReady high at a clock edge), frameValid stays low until frameDone has been seen.
- R8: A start pulse while busy has no effect on the frames or on busy.
- R9: done rises in the cycle after frameDone for the final write frame and stays high until the next start. A start while done clears done and runs the whole programme again.
- R10: portSel is sampled only when the start pulse is accepted. Later changes do not alter the frames of the running programme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the programme |
| portSel | input | 1 | Transceiver instance (port address 0 or 1) |
| frameValid | output | 1 | A frame is offered |
| frameData | output | 32 | Frame contents |
| frameReady | input | 1 | Engine accepts the offered frame |
| frameDone | input | 1 | Engine finished the outstanding frame |
| busy | output | 1 | Programme in progress |
| done | output | 1 | Programme finished |

## Verification
The bench builds the block with its default parameters: four lanes, a lane stride of 4, and the base addresses and values listed above. This gives the full 34-frame programme.

Runs on both ports are compared frame by frame against a table of the 17 writes. The runs differ in how long the engine holds off ready and done, which exercises the hold and wait rules. One run pulses start and flips the port select mid-programme, so the ignore and sampling rules show up directly in the frames. A restart from the done state covers the done clearing rule.

// File: rtl/serdes_init_pkg.sv
package serdes_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_WAIT    = 2'd2,
    ST_DONE    = 2'd3
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // restart at the first write, address phase
    logic latchPort;  // capture the port select
    logic advance;    // step to the next frame
  } seq_strobe_t;

  localparam logic [1:0] MDIO_START_C45 = 2'b00;
  localparam logic [1:0] MDIO_OP_ADDR   = 2'b00;
  localparam logic [1:0] MDIO_OP_WRITE  = 2'b01;
  localparam logic [1:0] MDIO_TURN      = 2'b10;
  localparam int         PRTAD_W        = 5;
  localparam int         DEVAD_W        = 5;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import serdes_init_pkg::*;
#(
  parameter int          NUM_LANES   = 4,
  parameter int          LANE_STRIDE = 4,
  parameter logic [15:0] TX_BASE     = 16'h8100,
  parameter logic [15:0] RX_BASE     = 16'h8120,
  parameter logic [15:0] PLL_ADDR    = 16'h8000,
  parameter logic [15:0] TX_LO_VAL   = 16'h9F01,
  parameter logic [15:0] TX_HI_VAL   = 16'h0000,
  parameter logic [15:0] RX_LO_VAL   = 16'h9101,
  parameter logic [15:0] RX_HI_VAL   = 16'h0008,
  parameter logic [15:0] PLL_VAL     = 16'h000B,
  parameter logic [4:0]  DEV_ADDR    = 5'h1E
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobes,
  input  logic        portSel,
  output logic        lastFrame,
  output logic [31:0] frameData
);

  localparam int GROUP      = 2 * NUM_LANES;
  localparam int NUM_WRITES = 2 * GROUP + 1;
  localparam int IDX_W      = $clog2(NUM_WRITES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WRITES - 1);

  logic [IDX_W-1:0] writeIdx;
  logic             dataPhase;
  logic             portReg;

  logic [15:0] entryAddr [NUM_WRITES];
  logic [15:0] entryData [NUM_WRITES];

  // write list: TX lanes, RX lanes, PLL enable last
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    assign entryAddr[2*g]           = TX_BASE + 16'(g * LANE_STRIDE);
    assign entryAddr[2*g+1]         = TX_BASE + 16'(g * LANE_STRIDE + 1);
    assign entryData[2*g]           = TX_LO_VAL;
    assign entryData[2*g+1]         = TX_HI_VAL;
    assign entryAddr[GROUP + 2*g]   = RX_BASE + 16'(g * LANE_STRIDE);
    assign entryAddr[GROUP + 2*g+1] = RX_BASE + 16'(g * LANE_STRIDE + 1);
    assign entryData[GROUP + 2*g]   = RX_LO_VAL;
    assign entryData[GROUP + 2*g+1] = RX_HI_VAL;
  end
  assign entryAddr[NUM_WRITES-1] = PLL_ADDR;
  assign entryData[NUM_WRITES-1] = PLL_VAL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeIdx  <= '0;
      dataPhase <= 1'b0;
      portReg   <= 1'b0;
    end else begin
      if (strobes.latchPort) portReg <= portSel;
      if (strobes.clear) begin
        writeIdx  <= '0;
        dataPhase <= 1'b0;
      end else if (strobes.advance) begin
        if (dataPhase) begin
          writeIdx  <= writeIdx + 1'b1;
          dataPhase <= 1'b0;
        end else begin
          dataPhase <= 1'b1;
        end
      end
    end
  end

  logic [IDX_W-1:0]   selIdx;
  logic [15:0]        payload;
  logic [1:0]         opcode;
  logic [PRTAD_W-1:0] prtad;

  always_comb begin
    selIdx  = (writeIdx <= LAST_IDX) ? writeIdx : '0;
    payload = dataPhase ? entryData[selIdx] : entryAddr[selIdx];
    opcode  = dataPhase ? MDIO_OP_WRITE : MDIO_OP_ADDR;
    prtad   = {{(PRTAD_W-1){1'b0}}, portReg};
  end

  assign frameData = {MDIO_START_C45, opcode, prtad, DEV_ADDR, MDIO_TURN, payload};
  assign lastFrame = dataPhase && (writeIdx == LAST_IDX);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import serdes_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        frameReady,
  input  logic        frameDone,
  input  logic        lastFrame,
  output seq_strobe_t strobes,
  output logic        frameValid,
  output logic        busy,
  output logic        done
);

  seq_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobes.clear     = 1'b1;
          strobes.latchPort = 1'b1;
          stateNext         = ST_PRESENT;
        end
      end
      ST_PRESENT: begin
        if (frameReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (frameDone) begin
          if (lastFrame) begin
            stateNext = ST_DONE;
          end else begin
            strobes.advance = 1'b1;
            stateNext       = ST_PRESENT;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign frameValid = (state == ST_PRESENT);
  assign busy       = (state == ST_PRESENT) || (state == ST_WAIT);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/serdes_init_seq.sv
module serdes_init_seq
  import serdes_init_pkg::*;
#(
  parameter int          NUM_LANES   = 4,
  parameter int          LANE_STRIDE = 4,
  parameter logic [15:0] TX_BASE     = 16'h8100,
  parameter logic [15:0] RX_BASE     = 16'h8120,
  parameter logic [15:0] PLL_ADDR    = 16'h8000,
  parameter logic [4:0]  DEV_ADDR    = 5'h1E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        portSel,
  output logic        frameValid,
  output logic [31:0] frameData,
  input  logic        frameReady,
  input  logic        frameDone,
  output logic        busy,
  output logic        done
);

  seq_strobe_t strobes;
  logic        lastFrame;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .frameReady (frameReady),
    .frameDone  (frameDone),
    .lastFrame  (lastFrame),
    .strobes    (strobes),
    .frameValid (frameValid),
    .busy       (busy),
    .done       (done)
  );

  seq_datapath #(
    .NUM_LANES   (NUM_LANES),
    .LANE_STRIDE (LANE_STRIDE),
    .TX_BASE     (TX_BASE),
    .RX_BASE     (RX_BASE),
    .PLL_ADDR    (PLL_ADDR),
    .DEV_ADDR    (DEV_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .portSel   (portSel),
    .lastFrame (lastFrame),
    .frameData (frameData)
  );

endmodule

// File: rtl/serdes_init_seq_chk.sv
module serdes_init_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        frameValid,
  input logic [31:0] frameData,
  input logic        frameReady,
  input logic        frameDone,
  input logic        busy,
  input logic        done
);

  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)                        outstanding <= 1'b0;
    else if (frameValid && frameReady) outstanding <= 1'b1;
    else if (frameDone)                outstanding <= 1'b0;
  end

  AST_FRAME_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (frameData[31:30] == 2'b00 && frameData[22:16] == 7'b1111010)); // R2

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameReady) |=> (frameValid && $stable(frameData))); // R6

  AST_QUIET_WHILE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !frameValid); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9

  AST_BUSY_HOLDS_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !frameDone) |=> busy); // R8

endmodule

bind serdes_init_seq serdes_init_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .frameValid (frameValid),
  .frameData  (frameData),
  .frameReady (frameReady),
  .frameDone  (frameDone),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_serdes_init_seq.sv
module tb_serdes_init_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        portSel = 1'b0;
  logic        frameValid;
  logic [31:0] frameData;
  logic        frameReady = 1'b0;
  logic        frameDone = 1'b0;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  serdes_init_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .portSel(portSel),
    .frameValid(frameValid), .frameData(frameData),
    .frameReady(frameReady), .frameDone(frameDone),
    .busy(busy), .done(done)
  );

  // {register address, data} in programme order (R4, R5)
  localparam logic [31:0] VEC [17] = '{
    {16'h8100, 16'h9F01}, {16'h8101, 16'h0000},
    {16'h8104, 16'h9F01}, {16'h8105, 16'h0000},
    {16'h8108, 16'h9F01}, {16'h8109, 16'h0000},
    {16'h810C, 16'h9F01}, {16'h810D, 16'h0000},
    {16'h8120, 16'h9101}, {16'h8121, 16'h0008},
    {16'h8124, 16'h9101}, {16'h8125, 16'h0008},
    {16'h8128, 16'h9101}, {16'h8129, 16'h0008},
    {16'h812C, 16'h9101}, {16'h812D, 16'h0008},
    {16'h8000, 16'h000B}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic port);
    @(negedge clk);
    portSel = port;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    check(!done && busy, "R9 restart clears done", {30'd0, busy, done}, 32'h2);
  endtask

  task automatic runProgramme(input logic port, input int readyDelay, input int doneDelay, input bit disturb);
    pulseStart(port);
    for (int k = 0; k < 34; k++) begin
      logic [31:0] exp;
      logic [15:0] upper;
      int          guard;
      guard = 0;
      while (!frameValid && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      upper = (k % 2 == 0) ? (port ? 16'h00FA : 16'h007A) : (port ? 16'h10FA : 16'h107A);
      exp   = {upper, (k % 2 == 0) ? VEC[k/2][31:16] : VEC[k/2][15:0]};
      for (int d = 0; d < readyDelay; d++) begin
        check(frameValid && frameData == exp, "R6 hold while not ready", frameData, exp);
        @(negedge clk);
      end
      if (k % 2 == 0)
        check(frameValid && frameData == exp, "R2 R4 address frame", frameData, exp);
      else
        check(frameValid && frameData == exp, "R3 R5 write frame", frameData, exp);
      frameReady = 1'b1;
      @(negedge clk);
      frameReady = 1'b0;
      check(!frameValid, "R7 no frame while outstanding", {31'd0, frameValid}, 32'd0);
      if (disturb && k == 5) begin
        portSel = ~port;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        check(busy && !frameValid, "R8 start ignored while busy", {30'd0, busy, frameValid}, 32'h2);
      end
      for (int d = 0; d < doneDelay; d++) begin
        @(negedge clk);
        check(!frameValid, "R7 waiting for done", {31'd0, frameValid}, 32'd0);
      end
      frameDone = 1'b1;
      @(negedge clk);
      frameDone = 1'b0;
    end
    check(done && !busy, "R9 done after final frame", {30'd0, busy, done}, 32'h1);
    repeat (3) @(negedge clk);
    check(done && !frameValid, "R9 done stays high", {30'd0, frameValid, done}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!frameValid && !busy && !done, "R1 reset state", {29'd0, frameValid, busy, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!frameValid && !busy && !done, "R1 idle after reset", {29'd0, frameValid, busy, done}, 32'd0);

    runProgramme(1'b0, 0, 0, 1'b0);
    runProgramme(1'b1, 2, 3, 1'b1);  // R8 and R10 disturbance
    runProgramme(1'b0, 1, 1, 1'b1);  // R10 port flip towards 1 ignored

    // done held without a start, even with frameDone noise: R9
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    @(negedge clk);
    check(done && !frameValid, "R9 done ignores stray frameDone", {30'd0, frameValid, done}, 32'h1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule